// File: doc/BRIEF.md
# Zero-Page Mapped Bidirectional Port

This block is an 8-bit parallel port that a processor reaches through its ordinary memory space. It decodes two zero-page addresses on the processor's internal bus. Address 0x0000 holds a direction register and address 0x0001 holds a data register. Each bit is configured on its own as an input or an output. Register writes are synchronous. Reads are combinational: a read-data mux produces the port value together with a hit flag, and the bus mux uses that flag to take port data in place of memory data.

Only bits 0 to 5 reach package pins. Bits 6 and 7 stay internal. For every pin the block drives an output-enable and an output value, taken straight from the two registers.

Each pin also has an external-drive qualifier. A pin that nothing drives resolves to 1, which models a pull-up. The resolved pin levels pass through a two-flop synchronizer before they reach the read mux. A read of the data register merges the latched bits of outputs with the synchronized levels of inputs.

Top module: `zp_port`

## Requirements
- R1: After reset the direction register and the data register are 0x00. Every pin_oe bit is therefore 0, and every bit is an input.
- R2: A write with wr_en high at address 0x0000 stores wdata in the direction register on the next rising clock edge. A read at 0x0000 returns all 8 stored bits.
- R3: A direction bit of 1 makes that bit an output and a 0 makes it an input. For bits 0 to 5, pin_oe[i] equals direction bit i. Writing 0x2F sets pin_oe to 6'b101111, so bits 0, 1, 2, 3 and 5 are outputs and bit 4 is an input.
- R4: A write at address 0x0001 latches wdata into the data register on the next rising edge, whatever the direction. pin_out[i] equals data bit i for bits 0 to 5, and a pin drives only while pin_oe[i] is 1.
- R5: A read at 0x0001 returns, for each bit, the latched data bit when the bit is an output and the synchronized pin level when it is an input.
- R6: Bits 6 and 7 have no pin. When configured as inputs they read as 1, and when configured as outputs they read back the latched value.
- R7: A pin whose ext_drive bit is 0 resolves to level 1, whatever pin_in carries. A pin whose ext_drive bit is 1 resolves to pin_in.
- R8: An input read shows the resolved pin level from two rising edges earlier. A change made between edges appears after exactly the second following edge.
- R9: For any address other than 0x0000 and 0x0001, hit is 0 and rdata is 0x00, and a write leaves both registers unchanged.
- R10: hit is 1 combinationally whenever addr is 0x0000 or 0x0001, whether wr_en is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor bus address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data, 0 when there is no hit |
| hit | output | 1 | Port claims the current address |
| pin_in | input | 6 | Pad input levels |
| ext_drive | input | 6 | 1 where an external source drives the pad |
| pin_oe | output | 6 | Per-pin output enable |
| pin_out | output | 6 | Per-pin output value |

## Verification
The assertions assume that addr, wr_en and wdata are stable around the rising edge. They also assume that pin_in and ext_drive change only between edges, so the synchronizer's first stage always captures a defined level. The bench changes every input on the falling edge only, and it samples rdata, hit and the pin outputs one step later, away from the active edge. The direction-register sweep covers all 256 codes. Each code is paired with its own data pattern and its own external-drive pattern, so output bits, driven inputs, undriven inputs and the two pinless bits are all exercised in every combination.

// File: rtl/zp_port_pkg.sv
package zp_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2
  } zp_sel_e;
endpackage

// File: rtl/zp_port_decode.sv
module zp_port_decode
  import zp_port_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output zp_sel_e           sel
);
  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);

  always_comb begin
    if (addr == DirA)       sel = SEL_DIR;
    else if (addr == DataA) sel = SEL_DATA;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/zp_port_regs.sv
module zp_port_regs
  import zp_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zp_sel_e           sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_DIR)  dir_q  <= wdata;
      if (sel == SEL_DATA) data_q <= wdata;
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

  assert_data_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> (data_q == $past(wdata)));

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel != SEL_NONE) |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/zp_port_sync.sv
module zp_port_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '1;
          else        stage[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '1;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

  assert_first_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage[0] == $past(d)));
endmodule

// File: rtl/zp_port_rdmux.sv
module zp_port_rdmux
  import zp_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIN_W  = 6
) (
  input  zp_sel_e           sel,
  input  logic [DATA_W-1:0] dir_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [PIN_W-1:0]  level,
  output logic [DATA_W-1:0] rdata,
  output logic              hit
);
  logic [DATA_W-1:0] in_view;
  logic [DATA_W-1:0] merged;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < PIN_W) begin : g_pin
        assign in_view[i] = level[i];
      end else begin : g_nopin
        assign in_view[i] = 1'b1;
      end
    end
  endgenerate

  assign merged = (dir_q & data_q) | (~dir_q & in_view);

  always_comb begin
    unique case (sel)
      SEL_DIR:  rdata = dir_q;
      SEL_DATA: rdata = merged;
      default:  rdata = '0;
    endcase
  end

  assign hit = (sel != SEL_NONE);
endmodule

// File: rtl/zp_port.sv
module zp_port
  import zp_port_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PIN_W     = 6,
  parameter int SYNC_N    = 2,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hit,
  input  logic [PIN_W-1:0]  pin_in,
  input  logic [PIN_W-1:0]  ext_drive,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  pin_out
);
  zp_sel_e          sel;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] data_q;
  logic [PIN_W-1:0]  pad_level;
  logic [PIN_W-1:0]  sync_level;

  zp_port_decode #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .addr(addr), .sel(sel)
  );

  zp_port_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
    .dir_q(dir_q), .data_q(data_q)
  );

  // undriven pads float high through the pull-up
  assign pad_level = (ext_drive & pin_in) | ~ext_drive;

  zp_port_sync #(.WIDTH(PIN_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_level), .q(sync_level)
  );

  zp_port_rdmux #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_rdmux (
    .sel(sel), .dir_q(dir_q), .data_q(data_q), .level(sync_level),
    .rdata(rdata), .hit(hit)
  );

  assign pin_oe  = dir_q[PIN_W-1:0];
  assign pin_out = data_q[PIN_W-1:0];

  assert_miss_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR_W'(DIR_ADDR) && addr != ADDR_W'(DATA_ADDR)) |-> (!hit && rdata == '0));

  assert_oe_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(DIR_ADDR)) |=> (pin_oe == $past(wdata[PIN_W-1:0])));

  assert_pinless_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(DATA_ADDR) && dir_q[DATA_W-1] == 1'b0) |-> rdata[DATA_W-1]);

  assert_hit_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(DIR_ADDR) || addr == ADDR_W'(DATA_ADDR)) |-> hit);
endmodule

// File: tb/tb_zp_port.sv
module tb_zp_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        hit;
  logic [5:0]  pin_in = 6'h00;
  logic [5:0]  ext_drive = 6'h00;
  logic [5:0]  pin_oe;
  logic [5:0]  pin_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zp_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .hit(hit), .pin_in(pin_in), .ext_drive(ext_drive),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic h);
    addr = a;
    #1;
    v = rdata;
    h = hit;
  endtask

  function automatic logic [7:0] expect_read(input logic [7:0] d, input logic [7:0] q,
                                             input logic [5:0] p, input logic [5:0] e);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (d[i])       r[i] = q[i];
      else if (i > 5) r[i] = 1'b1;
      else            r[i] = e[i] ? p[i] : 1'b1;
    end
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       h;
    logic [7:0] dv;
    logic [7:0] qv;
    logic [5:0] pv;
    logic [5:0] ev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(16'h0000, v, h);
    check("R1 dir reset", {8'h00, v}, 16'h0000);
    check("R1 oe reset", {10'h000, pin_oe}, 16'h0000);
    rd(16'h0001, v, h);
    check("R1 all inputs undriven read", {8'h00, v}, 16'h00FF);
    check("R10 hit on data addr read", {15'h0, h}, 16'h0001);

    // R3 0x2F direction code
    wr(16'h0000, 8'h2F);
    check("R3 oe for 0x2F", {10'h000, pin_oe}, 16'h002F);
    rd(16'h0000, v, h);
    check("R2 dir readback 0x2F", {8'h00, v}, 16'h002F);

    // R2..R7 sweep all direction codes
    for (int d = 0; d < 256; d++) begin
      dv = 8'(d);
      qv = dv ^ 8'hA5;
      pv = 6'(d * 7 + 3);
      ev = 6'(d >> 1) ^ 6'h2A;
      wr(16'h0000, dv);
      wr(16'h0001, qv);
      @(negedge clk);
      pin_in = pv; ext_drive = ev;
      repeat (2) @(negedge clk);
      rd(16'h0000, v, h);
      check("R2 dir readback", {8'h00, v}, {8'h00, dv});
      check("R3 oe tracks dir", {10'h000, pin_oe}, {10'h000, dv[5:0]});
      check("R4 pin_out tracks data", {10'h000, pin_out}, {10'h000, qv[5:0]});
      rd(16'h0001, v, h);
      check("R5 R6 R7 merged read", {8'h00, v}, {8'h00, expect_read(dv, qv, pv, ev)});
    end

    // R8 two-edge latency on an input bit
    wr(16'h0000, 8'h00);
    @(negedge clk);
    ext_drive = 6'h3F; pin_in = 6'h00;
    repeat (3) @(negedge clk);
    pin_in = 6'h15;
    rd(16'h0001, v, h);
    check("R8 before edges", {8'h00, v}, 16'h00C0);
    @(negedge clk);
    rd(16'h0001, v, h);
    check("R8 after one edge", {8'h00, v}, 16'h00C0);
    @(negedge clk);
    rd(16'h0001, v, h);
    check("R8 after two edges", {8'h00, v}, 16'h00D5);

    // R7 undriven pins float high even with pin_in low
    @(negedge clk);
    ext_drive = 6'h00; pin_in = 6'h00;
    repeat (2) @(negedge clk);
    rd(16'h0001, v, h);
    check("R7 undriven reads one", {8'h00, v}, 16'h00FF);

    // R9 other addresses: no hit, zero data, writes ignored
    wr(16'h0000, 8'h5A);
    wr(16'h0001, 8'h3C);
    for (int a = 2; a < 260; a++) begin
      wr(16'(a), 8'hFF ^ 8'(a));
      rd(16'(a), v, h);
      check("R9 miss hit low", {15'h0, h}, 16'h0000);
      check("R9 miss rdata zero", {8'h00, v}, 16'h0000);
    end
    wr(16'hFFFF, 8'h00);
    wr(16'h8000, 8'h00);
    wr(16'h0100, 8'h00);
    rd(16'h0000, v, h);
    check("R9 dir unchanged", {8'h00, v}, 16'h005A);
    check("R9 oe unchanged", {10'h000, pin_oe}, 16'h001A);
    check("R9 pin_out unchanged", {10'h000, pin_out}, 16'h003C);

    // R10 hit with wr_en low and high
    @(negedge clk);
    wr_en = 1'b0;
    rd(16'h0000, v, h);
    check("R10 hit dir addr idle", {15'h0, h}, 16'h0001);
    wr_en = 1'b1; wdata = 8'h5A;
    rd(16'h0001, v, h);
    check("R10 hit data addr writing", {15'h0, h}, 16'h0001);
    @(negedge clk);
    wr_en = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule